// File: doc/BRIEF.md
# TDM Slot-Mapped Stereo Serial Transceiver

This block is a frame-based serial engine for a time-division-multiplexed audio link. It generates a serial clock and a frame-sync pulse. Each frame is cut into fixed 16-bit slots. In every slot it shifts a 16-bit word out on the data output and shifts a 16-bit word in from the data input. Four logical channels exist in each direction: left data, right data, control 0 and control 1. Each channel has an enable and a 4-bit slot index, so the channels can be placed in any order within the frame.

The data channels have separate transmit and receive settings. Each control channel has one setting that serves both directions. Software-facing storage is reduced to holding words. The transmit words are presented in parallel on an input bus. The received words are kept in holding registers on an output bus, and a one-cycle strobe marks each update. While `run` is high the link runs continuously. Dropping `run` parks the link.

Top module: `tdm_slot_xcvr`

## Requirements
- R1: A 4-bit frame code sets the frame length. Codes 1011, 1100, 1101, 1110 and 1111 give 1, 2, 4, 8 and 16 slots of 16 bits, so 1110 gives a 128-bit frame. Every code below 1011 gives one slot. Slots are numbered from 0, and the frame wraps to slot 0 after its last bit.
- R2: Each bit period lasts two clock cycles. `sck` is low in the first cycle and high in the second. `txd` changes only when `sck` falls.
- R3: `fsync` is high for exactly one bit period per frame. With `sync_late`=0 it coincides with bit 0 of slot 0. With `sync_late`=1 it occupies the last bit period of the previous frame. With `sync_late`=1, the first frame after `run` rises is preceded by one lead-in bit period in which `fsync`=1 and `txd`=0.
- R4: Within a slot, bits are sent MSB first. The sender is the enabled transmit channel whose slot index equals the slot number. Channel c uses `tx_word[16c+15:16c]`, where c=0 is left, 1 is right, 2 is control 0 and 3 is control 1.
- R5: A channel's transmit word is captured at the start of its slot. Changes to `tx_word` during that slot have no effect on the bits sent.
- R6: `txd` is 0 in any slot that no enabled transmit channel claims.
- R7: Received bits are assembled MSB first. With `rx_rise`=1, `rxd` is sampled on the rising edge of `sck`. With `rx_rise`=0, it is sampled on the falling edge that ends the bit. Receive channel c uses the same lane numbering as R4.
- R8: After a slot's last bit, the claiming receive channel's word in `rx_word` is updated, and `rx_valid[c]` pulses for one cycle. Channels that do not claim a slot keep their word and raise no strobe.
- R9: If two enabled channels of the same direction share a slot index, the lower channel number wins. The losing channel neither sends nor receives in that slot.
- R10: One cycle after `run` is low, `sck`, `fsync` and `txd` are low and the frame restarts from its beginning. The `rx_word` contents are held.
- R11: After reset, `sck`, `fsync`, `txd` and `rx_valid` are 0, and `rx_word` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Link enable |
| frame_code | input | 4 | Frame length code |
| sync_late | input | 1 | Sync one bit ahead of slot 0 |
| rx_rise | input | 1 | Receive sampling edge: 1 rising, 0 falling |
| tx_data_en | input | 2 | Transmit enables: bit 0 left, bit 1 right |
| tx_data_slot | input | 8 | Transmit slot indices: [3:0] left, [7:4] right |
| rx_data_en | input | 2 | Receive enables: bit 0 left, bit 1 right |
| rx_data_slot | input | 8 | Receive slot indices: [3:0] left, [7:4] right |
| ctl_en | input | 2 | Control channel enables, both directions |
| ctl_slot | input | 8 | Control channel slot indices: [3:0] ctl 0, [7:4] ctl 1 |
| tx_word | input | 64 | Transmit words, 16 bits per channel |
| rx_word | output | 64 | Received holding words, 16 bits per channel |
| rx_valid | output | 4 | One-cycle update strobe per channel |
| sck | output | 1 | Serial clock |
| fsync | output | 1 | Frame sync pulse |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |

## Verification
The bench uses the default parameters: 16-bit slots and 4-bit slot indices. With these defaults the longest frame code gives sixteen slots, so slot index 15 is reachable. Short frame codes leave many indices unreachable, which checks that unplaced channels stay silent. The random slot indices are drawn mostly from the slots of the current frame, so collisions between channels are frequent. The bench drives a different `rxd` value in each half of every bit, which tells the two sampling edges apart.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
    localparam int unsigned NUM_CH       = 4;
    localparam int          FL_CODE_BASE = 11;

    typedef enum logic [1:0] {
        CH_LEFT  = 2'd0,
        CH_RIGHT = 2'd1,
        CH_CTL0  = 2'd2,
        CH_CTL1  = 2'd3
    } chan_e;
endpackage

// File: rtl/tdm_slot_arbiter.sv
module tdm_slot_arbiter #(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned NCH   = 4,
    localparam int unsigned SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0]       en,
    input  logic [NCH*IDX_W-1:0] idx,
    input  logic [IDX_W-1:0]     slot,
    output logic                 hit,
    output logic [SEL_W-1:0]     sel
);
    logic [NCH-1:0] match;

    for (genvar c = 0; c < NCH; c++) begin : g_match
        assign match[c] = en[c] && (idx[c*IDX_W +: IDX_W] == slot);
    end

    // scan downward so the lowest matching channel is written last
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (match[c]) begin
                hit = 1'b1;
                sel = SEL_W'(c);
            end
        end
    end
endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
    parameter int unsigned SLOT_BITS = 16,
    parameter int unsigned IDX_W     = 4,
    parameter int unsigned CODE_W    = 4,
    localparam int unsigned BIT_W    = $clog2(SLOT_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] frame_code,
    input  logic              sync_late,
    output logic              sck,
    output logic              fsync,
    output logic [IDX_W-1:0]  cur_slot,
    output logic [IDX_W-1:0]  nxt_slot,
    output logic              slot_load,
    output logic              bit_end,
    output logic              bit_last,
    output logic              samp_rise,
    output logic              samp_fall
);
    localparam logic [BIT_W-1:0] BIT_MAX = BIT_W'(SLOT_BITS - 1);

    typedef struct packed {
        logic             active;
        logic             phase;
        logic             lead;
        logic             sync;
        logic [BIT_W-1:0] bitc;
        logic [IDX_W-1:0] slot;
    } tmr_t;

    tmr_t             tmr_d, tmr_q;
    logic [IDX_W-1:0] last_slot;
    logic             load_d;

    // frame length decode: one slot below the base code, doubling above it
    always_comb begin
        int sh;
        sh = int'(frame_code) - tdm_pkg::FL_CODE_BASE;
        if (sh <= 0) begin
            last_slot = '0;
        end else if (sh >= int'(IDX_W)) begin
            last_slot = '1;
        end else begin
            last_slot = IDX_W'((32'd1 << sh) - 32'd1);
        end
    end

    always_comb begin
        tmr_d  = tmr_q;
        load_d = 1'b0;
        if (!run) begin
            tmr_d = '0;
        end else if (!tmr_q.active) begin
            tmr_d.active = 1'b1;
            tmr_d.phase  = 1'b0;
            tmr_d.lead   = sync_late;
            tmr_d.bitc   = '0;
            tmr_d.slot   = '0;
            tmr_d.sync   = 1'b1;
            load_d       = !sync_late;
        end else if (!tmr_q.phase) begin
            tmr_d.phase = 1'b1;
        end else begin
            tmr_d.phase = 1'b0;
            if (tmr_q.lead) begin
                tmr_d.lead = 1'b0;
                tmr_d.bitc = '0;
                tmr_d.slot = '0;
            end else if (tmr_q.bitc == BIT_MAX) begin
                tmr_d.bitc = '0;
                tmr_d.slot = (tmr_q.slot >= last_slot) ? '0 : tmr_q.slot + 1'b1;
            end else begin
                tmr_d.bitc = tmr_q.bitc + 1'b1;
            end
            if (sync_late) begin
                tmr_d.sync = (tmr_d.bitc == BIT_MAX) && (tmr_d.slot == last_slot);
            end else begin
                tmr_d.sync = (tmr_d.bitc == '0) && (tmr_d.slot == '0);
            end
            load_d = (tmr_d.bitc == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign sck       = tmr_q.phase;
    assign fsync     = tmr_q.sync;
    assign cur_slot  = tmr_q.slot;
    assign nxt_slot  = tmr_d.slot;
    assign slot_load = load_d;
    assign bit_end   = run && tmr_q.active && tmr_q.phase;
    assign bit_last  = (tmr_q.bitc == BIT_MAX);
    assign samp_rise = run && tmr_q.active && !tmr_q.lead && !tmr_q.phase;
    assign samp_fall = run && tmr_q.active && !tmr_q.lead && tmr_q.phase;
endmodule

// File: rtl/tdm_slot_xcvr.sv
module tdm_slot_xcvr #(
    parameter int unsigned SLOT_BITS = 16,
    parameter int unsigned IDX_W     = 4,
    parameter int unsigned CODE_W    = 4,
    localparam int unsigned NCH      = tdm_pkg::NUM_CH,
    localparam int unsigned SEL_W    = $clog2(NCH),
    localparam int unsigned WORD_W   = NCH * SLOT_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [CODE_W-1:0]   frame_code,
    input  logic                sync_late,
    input  logic                rx_rise,
    input  logic [1:0]          tx_data_en,
    input  logic [2*IDX_W-1:0]  tx_data_slot,
    input  logic [1:0]          rx_data_en,
    input  logic [2*IDX_W-1:0]  rx_data_slot,
    input  logic [1:0]          ctl_en,
    input  logic [2*IDX_W-1:0]  ctl_slot,
    input  logic [WORD_W-1:0]   tx_word,
    output logic [WORD_W-1:0]   rx_word,
    output logic [NCH-1:0]      rx_valid,
    output logic                sck,
    output logic                fsync,
    output logic                txd,
    input  logic                rxd
);
    typedef struct packed {
        logic [SLOT_BITS-1:0] tx_sh;
        logic [SLOT_BITS-1:0] rx_sh;
        logic [WORD_W-1:0]    rx_word;
        logic [NCH-1:0]       rx_valid;
    } dp_t;

    dp_t                  dp_d, dp_q;
    logic [NCH-1:0]       tx_en_v, rx_en_v;
    logic [NCH*IDX_W-1:0] tx_idx_v, rx_idx_v;
    logic [IDX_W-1:0]     cur_slot, nxt_slot;
    logic                 slot_load, bit_end, bit_last, samp_rise, samp_fall;
    logic                 tx_hit, rx_hit;
    logic [SEL_W-1:0]     tx_sel, rx_sel;
    logic                 sample;
    logic [SLOT_BITS-1:0] rx_next;

    // lane order: left, right, control 0, control 1 (lowest wins conflicts)
    assign tx_en_v  = {ctl_en, tx_data_en};
    assign rx_en_v  = {ctl_en, rx_data_en};
    assign tx_idx_v = {ctl_slot, tx_data_slot};
    assign rx_idx_v = {ctl_slot, rx_data_slot};

    tdm_frame_timer #(
        .SLOT_BITS (SLOT_BITS),
        .IDX_W     (IDX_W),
        .CODE_W    (CODE_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .frame_code (frame_code),
        .sync_late  (sync_late),
        .sck        (sck),
        .fsync      (fsync),
        .cur_slot   (cur_slot),
        .nxt_slot   (nxt_slot),
        .slot_load  (slot_load),
        .bit_end    (bit_end),
        .bit_last   (bit_last),
        .samp_rise  (samp_rise),
        .samp_fall  (samp_fall)
    );

    tdm_slot_arbiter #(.IDX_W(IDX_W), .NCH(NCH)) u_tx_arb (
        .en   (tx_en_v),
        .idx  (tx_idx_v),
        .slot (nxt_slot),
        .hit  (tx_hit),
        .sel  (tx_sel)
    );

    tdm_slot_arbiter #(.IDX_W(IDX_W), .NCH(NCH)) u_rx_arb (
        .en   (rx_en_v),
        .idx  (rx_idx_v),
        .slot (cur_slot),
        .hit  (rx_hit),
        .sel  (rx_sel)
    );

    assign sample  = rx_rise ? samp_rise : samp_fall;
    assign rx_next = {dp_q.rx_sh[SLOT_BITS-2:0], rxd};

    always_comb begin
        dp_d          = dp_q;
        dp_d.rx_valid = '0;
        if (!run) begin
            dp_d.tx_sh = '0;
            dp_d.rx_sh = '0;
        end else begin
            if (slot_load) begin
                dp_d.tx_sh = tx_hit ? tx_word[tx_sel*SLOT_BITS +: SLOT_BITS] : '0;
            end else if (bit_end) begin
                dp_d.tx_sh = {dp_q.tx_sh[SLOT_BITS-2:0], 1'b0};
            end
            if (sample) begin
                dp_d.rx_sh = rx_next;
                if (bit_last && rx_hit) begin
                    dp_d.rx_word[rx_sel*SLOT_BITS +: SLOT_BITS] = rx_next;
                    dp_d.rx_valid[rx_sel] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign txd      = dp_q.tx_sh[SLOT_BITS-1];
    assign rx_word  = dp_q.rx_word;
    assign rx_valid = dp_q.rx_valid;
endmodule

// File: rtl/tdm_xcvr_checker.sv
module tdm_xcvr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       run,
    input logic       sck,
    input logic       fsync,
    input logic       txd,
    input logic [3:0] rx_valid
);
    AST_SCK_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        sck |=> !sck); // R2

    AST_TXD_HELD_IN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(txd)); // R2

    AST_SYNC_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync) |-> !sck); // R3

    AST_SYNC_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync && sck) |=> !fsync); // R3

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid != 4'd0) |=> (rx_valid == 4'd0)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!sck && !fsync && !txd)); // R10

    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (rx_valid == 4'd0)); // R10
endmodule

bind tdm_slot_xcvr tdm_xcvr_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .sck      (sck),
    .fsync    (fsync),
    .txd      (txd),
    .rx_valid (rx_valid)
);

// File: tb/sim_tdm_slot_xcvr.sv
`timescale 1ns/1ps
module sim_tdm_slot_xcvr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [3:0]  frame_code = 4'b1110;
    logic        sync_late = 1'b0;
    logic        rx_rise = 1'b1;
    logic [1:0]  tx_data_en = '0;
    logic [7:0]  tx_data_slot = '0;
    logic [1:0]  rx_data_en = '0;
    logic [7:0]  rx_data_slot = '0;
    logic [1:0]  ctl_en = '0;
    logic [7:0]  ctl_slot = '0;
    logic [63:0] tx_word = '0;
    logic [63:0] rx_word;
    logic [3:0]  rx_valid;
    logic        sck, fsync, txd;
    logic        rxd = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int vcnt[4];
    bit done = 1'b0;

    always #10 clk = ~clk;

    tdm_slot_xcvr u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .frame_code(frame_code),
        .sync_late(sync_late), .rx_rise(rx_rise),
        .tx_data_en(tx_data_en), .tx_data_slot(tx_data_slot),
        .rx_data_en(rx_data_en), .rx_data_slot(rx_data_slot),
        .ctl_en(ctl_en), .ctl_slot(ctl_slot), .tx_word(tx_word),
        .rx_word(rx_word), .rx_valid(rx_valid), .sck(sck), .fsync(fsync),
        .txd(txd), .rxd(rxd)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int slots_of(input logic [3:0] code);
        if (code < 4'd11) return 1;
        return 1 << (int'(code) - 11);
    endfunction

    function automatic int owner(input logic [3:0] en, input logic [15:0] idx, input int s);
        for (int c = 0; c < 4; c++)
            if (en[c] && idx[c*4 +: 4] == 4'(s)) return c;
        return -1;
    endfunction

    task automatic tick();
        @(negedge clk);
        for (int c = 0; c < 4; c++) vcnt[c] += int'(rx_valid[c]);
    endtask

    task automatic run_frame(input bit mutate);
        int ns = slots_of(frame_code);
        int fl = ns * 16;
        logic [15:0] tx_exp[16];
        logic [15:0] tx_got[16];
        logic [15:0] rx_a[16];
        logic [15:0] rx_b[16];
        logic [63:0] prev = rx_word;
        logic [3:0]  txe = {ctl_en, tx_data_en};
        logic [15:0] txi = {ctl_slot, tx_data_slot};
        logic [3:0]  rxe = {ctl_en, rx_data_en};
        logic [15:0] rxi = {ctl_slot, rx_data_slot};
        bit sync_ok = 1'b1;
        bit clk_ok = 1'b1;
        string tx_req;
        for (int s = 0; s < 16; s++) begin
            rx_a[s] = 16'($urandom);
            rx_b[s] = 16'($urandom);
            tx_got[s] = '0;
            tx_exp[s] = '0;
        end
        for (int c = 0; c < 4; c++) vcnt[c] = 0;
        run = 1'b1;
        tick();
        check(fsync == 1'b1, "R3", "sync in first bit period", 64'(fsync), 64'd1);
        if (sync_late) begin
            check(txd == 1'b0, "R3", "lead-in txd", 64'(txd), 64'd0);
            tick();
            tick();
        end
        for (int pos = 0; pos < fl; pos++) begin
            int s = pos / 16;
            int b = pos % 16;
            logic tbit;
            logic exp_sync = sync_late ? (pos == fl - 1) : (pos == 0);
            if (b == 0) begin
                int o = owner(txe, txi, s);
                tx_exp[s] = (o < 0) ? 16'd0 : tx_word[o*16 +: 16];
            end
            tbit = txd;
            tx_got[s][15-b] = tbit;
            if (fsync !== exp_sync || sck !== 1'b0) sync_ok = 1'b0;
            rxd = rx_a[s][15-b];
            if (mutate && b == 3) tx_word = {$urandom, $urandom};
            tick();
            if (sck !== 1'b1 || txd !== tbit) clk_ok = 1'b0;
            if (fsync !== exp_sync) sync_ok = 1'b0;
            rxd = rx_b[s][15-b];
            tick();
        end
        check(fsync == !sync_late, "R1", "frame wraps after its length", 64'(fsync), 64'(!sync_late));
        run = 1'b0;
        tick();
        check(!sck && !fsync && !txd, "R10", "outputs parked after run low",
              {61'd0, sck, fsync, txd}, 64'd0);
        tick();
        check(sync_ok, "R3", "sync position within frame", 64'(sync_ok), 64'd1);
        check(clk_ok, "R2", "sck phases and txd hold", 64'(clk_ok), 64'd1);
        for (int s = 0; s < ns; s++) begin
            if (mutate) tx_req = "R5";
            else if (owner(txe, txi, s) < 0) tx_req = "R6";
            else tx_req = "R4";
            check(tx_got[s] == tx_exp[s], tx_req, $sformatf("tx slot %0d", s),
                  64'(tx_got[s]), 64'(tx_exp[s]));
        end
        for (int c = 0; c < 4; c++) begin
            int ws = -1;
            bit contested = 1'b0;
            logic [15:0] exp_w;
            string req;
            for (int s = 0; s < ns; s++) begin
                if (owner(rxe, rxi, s) == c) ws = s;
                else if (rxe[c] && rxi[c*4 +: 4] == 4'(s)) contested = 1'b1;
            end
            if (ws >= 0) begin
                exp_w = rx_rise ? rx_a[ws] : rx_b[ws];
                req = "R7";
            end else begin
                exp_w = prev[c*16 +: 16];
                req = contested ? "R9" : "R8";
            end
            check(rx_word[c*16 +: 16] == exp_w, req, $sformatf("rx word lane %0d", c),
                  64'(rx_word[c*16 +: 16]), 64'(exp_w));
            check(vcnt[c] == ((ws >= 0) ? 1 : 0), (ws >= 0) ? "R8" : req,
                  $sformatf("strobe count lane %0d", c), 64'(vcnt[c]), 64'((ws >= 0) ? 1 : 0));
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R11 reset state
        check(!sck && !fsync && !txd, "R11", "serial outputs after reset", {61'd0, sck, fsync, txd}, 64'd0);
        check(rx_word == 64'd0, "R11", "holding words after reset", rx_word, 64'd0);
        check(rx_valid == 4'd0, "R11", "strobes after reset", 64'(rx_valid), 64'd0);

        // directed: ordered layout, late sync, falling-edge sampling
        frame_code = 4'b1110; sync_late = 1'b1; rx_rise = 1'b0;
        tx_data_en = 2'b11; rx_data_en = 2'b11; ctl_en = 2'b11;
        tx_data_slot = {4'd1, 4'd0}; rx_data_slot = {4'd1, 4'd0}; ctl_slot = {4'd3, 4'd2};
        tx_word = 64'h1234_ABCD_8001_F00F;
        run_frame(1'b0);

        // directed: interleaved layout, rising-edge sampling
        sync_late = 1'b1; rx_rise = 1'b1;
        tx_data_slot = {4'd2, 4'd0}; rx_data_slot = {4'd2, 4'd0}; ctl_slot = {4'd3, 4'd1};
        run_frame(1'b0);

        // directed: all channels on one slot (R9), early sync
        sync_late = 1'b0;
        tx_data_slot = {4'd5, 4'd5}; rx_data_slot = {4'd5, 4'd5}; ctl_slot = {4'd5, 4'd5};
        run_frame(1'b0);

        // directed: shortest frame, only lane 3 fits in slot 0 (R1)
        frame_code = 4'b0011; tx_data_en = 2'b00; rx_data_en = 2'b01; ctl_en = 2'b10;
        rx_data_slot = {4'd0, 4'd1}; ctl_slot = {4'd0, 4'd0};
        run_frame(1'b0);

        // directed: longest frame, channel at slot index 15 (R1)
        frame_code = 4'b1111; sync_late = 1'b1;
        tx_data_en = 2'b01; rx_data_en = 2'b10; ctl_en = 2'b00;
        tx_data_slot = {4'd0, 4'd15}; rx_data_slot = {4'd15, 4'd0};
        run_frame(1'b0);

        // directed: words rewritten inside their slots (R5)
        frame_code = 4'b1110; tx_data_en = 2'b11; ctl_en = 2'b11;
        tx_data_slot = {4'd4, 4'd1}; ctl_slot = {4'd7, 4'd6};
        run_frame(1'b1);

        // constrained random frames
        for (int f = 0; f < 40; f++) begin
            int ns;
            frame_code = ($urandom % 3 == 0) ? 4'(11 + $urandom % 5) : 4'b1110;
            ns = slots_of(frame_code);
            sync_late = 1'($urandom);
            rx_rise = 1'($urandom);
            tx_data_en = 2'($urandom); rx_data_en = 2'($urandom); ctl_en = 2'($urandom);
            for (int c = 0; c < 2; c++) begin
                tx_data_slot[c*4 +: 4] = ($urandom % 4 == 0) ? 4'($urandom) : 4'($urandom % ns);
                rx_data_slot[c*4 +: 4] = ($urandom % 4 == 0) ? 4'($urandom) : 4'($urandom % ns);
                ctl_slot[c*4 +: 4]     = ($urandom % 4 == 0) ? 4'($urandom) : 4'($urandom % ns);
            end
            tx_word = {$urandom, $urandom};
            run_frame(f % 7 == 3);
        end
        finish_up();
    end
endmodule